// File: doc/BRIEF.md
# SPI Register Access Master

This block lets on-chip logic read or write a single 8-bit register inside an external peripheral over a full-duplex SPI link, with the block acting as bus master. The caller places a 5-bit register number, a direction flag and (for writes) a data byte on its inputs, then pulses `start`. The block frames exactly two bytes under one select-low period: a command byte and a data byte.

While the command byte goes out, the peripheral returns a status byte. The block hands that byte back for both reads and writes. During the second byte the block sends the write data, or zero for a read, and captures the returned byte as the register value. The serial clock rate is set by the `DIV` parameter, which gives the number of system clocks in each SCLK half-period. A fixed select-high gap separates consecutive transactions.

Top module: `spi_reg_master`

## Requirements
- R1: Out of reset and whenever no transaction is active, `ss_n`=1, `sclk`=0, `mosi`=0 and `busy`=0. After reset, `done`=0, `rdata`=0x00 and `status`=0x00.
- R2: The first byte shifted out is the command. Bits 7:3 hold `reg_addr`, bit 1 is 1 for a write (`wr`=1) and 0 for a read, and bits 2 and 0 are 0. Bits go out most-significant first.
- R3: The second byte shifted out is `wdata` for a write and 0x00 for a read, also most-significant first.
- R4: `ss_n` falls one clock after an accepted `start`. SCLK then makes 16 pulses, and each low phase and each high phase lasts `DIV` clocks, with the low phase first. `mosi` changes only while `sclk` is low, and `sclk` is low whenever `ss_n` is high.
- R5: `miso` is sampled at the clock edge that ends each SCLK high phase.
- R6: `status` takes the 8 bits received during the command byte, MSB first, for both reads and writes.
- R7: `rdata` takes the 8 bits received during the second byte (the register value on a read).
- R8: `done` is a one-clock pulse in the same cycle that `ss_n` returns high, 32·`DIV` clocks after `ss_n` fell. `status` and `rdata` are updated in that cycle and hold their values until the next `done`.
- R9: `busy` is 1 from the clock after an accepted `start` until the select-high gap ends. A `start` seen while `busy` is 1 is ignored.
- R10: After `done`, `busy` stays 1 for 2·`DIV` clocks. Two transactions are therefore separated by at least 2·`DIV` clocks of `ss_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction when idle |
| wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Peripheral register number |
| wdata | input | 8 | Data byte for a write |
| busy | output | 1 | Transaction or gap in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte received in the data phase |
| status | output | 8 | Byte received in the command phase |
| ss_n | output | 1 | Active-low slave select |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
The following hold on every cycle and are checked by assertions:
- the idle line levels;
- SCLK being held low outside the select window;
- MOSI staying stable through each high phase;
- the shape of the `done` pulse and its alignment with the rise of `ss_n`;
- the minimum select-high gap;
- select only ever falling after an accepted `start`.

Some behaviours depend on values and appear only in the bench scenarios, which compare the design against a cycle-by-cycle reference model and a bit-capturing peripheral model. These are:
- the exact command encoding and data-byte contents;
- the sampling point of MISO and the resulting `status` and `rdata` bytes;
- the 32·`DIV` transaction length;
- a `start` that arrives mid-transfer being dropped.

// File: rtl/spi_reg_master.sv
module spi_reg_master #(
  parameter int DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       wr,
  input  logic [4:0] reg_addr,
  input  logic [7:0] wdata,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdata,
  output logic [7:0] status,
  output logic       ss_n,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);

  localparam int CW = $clog2(2 * DIV) + 1;
  localparam int NBITS = 16;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [3:0]    bitn;
  logic [15:0]   tx;
  logic [14:0]   rx;

  wire [7:0] cmd      = {reg_addr, 1'b0, wr, 1'b0};
  wire       half_end = (cnt == CW'(DIV - 1));
  wire       gap_end  = (cnt == CW'(2 * DIV - 1));

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      tx     <= '0;
      rx     <= '0;
      ss_n   <= 1'b1;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
      done   <= 1'b0;
      rdata  <= '0;
      status <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          tx   <= {cmd, wr ? wdata : 8'h00};
          mosi <= cmd[7];
          ss_n <= 1'b0;
          sclk <= 1'b0;
          cnt  <= '0;
          bitn <= '0;
          st   <= S_SHIFT;
        end
        S_SHIFT: begin
          if (!half_end) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              rx   <= {rx[13:0], miso};
              if (bitn == 4'(NBITS - 1)) begin
                ss_n   <= 1'b1;
                mosi   <= 1'b0;
                done   <= 1'b1;
                status <= rx[14:7];
                rdata  <= {rx[6:0], miso};
                st     <= S_GAP;
              end else begin
                bitn <= bitn + 1'b1;
                tx   <= {tx[14:0], 1'b0};
                mosi <= tx[14];
              end
            end
          end
        end
        S_GAP: begin
          if (gap_end) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hi_cnt <= CW'(2 * DIV);
    else if (!ss_n)
      hi_cnt <= '0;
    else if (hi_cnt != CW'(2 * DIV))
      hi_cnt <= hi_cnt + 1'b1;
  end

  assert_idle_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ss_n && !sclk && !mosi));

  assert_sclk_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !sclk);

  assert_mosi_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));

  assert_done_at_ss_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ss_n && $past(!ss_n)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_covers_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_select_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n) |-> $past(start && !busy));

  assert_min_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n) |-> (hi_cnt >= CW'(2 * DIV)));

endmodule

// File: tb/sim_spi_reg_master.sv
module sim_spi_reg_master;
  localparam int DIV = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] wdata = '0;
  logic       miso = 1'b0;
  logic       busy, done, ss_n, sclk, mosi;
  logic [7:0] rdata, status;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spi_reg_master #(.DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .reg_addr(reg_addr),
    .wdata(wdata), .busy(busy), .done(done), .rdata(rdata), .status(status),
    .ss_n(ss_n), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cmd_of(input logic [4:0] r, input logic w);
    return {r, 1'b0, w, 1'b0};
  endfunction

  // peripheral model: returns sresp MSB first, captures mosi on rising sclk
  logic [15:0] sresp = '0;
  logic [15:0] scap = '0;
  int rises = 0;
  always @(posedge sclk or posedge ss_n) begin
    if (ss_n) rises = 0;
    else begin
      scap = {scap[14:0], mosi};
      rises++;
    end
  end
  always @(negedge ss_n or negedge sclk) begin
    if (!ss_n) miso = (rises < 16) ? sresp[15 - rises] : 1'b0;
  end

  // cycle-by-cycle reference model
  int k = -1;
  logic [15:0] mframe = '0, mresp = '0;
  logic [7:0] exp_st = '0, exp_rd = '0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k = -1; exp_st = '0; exp_rd = '0;
    end else begin
      if (k >= 0) begin
        k++;
        if (k == 34 * DIV) k = -1;
      end else if (start) begin
        k = 0;
        mframe = {cmd_of(reg_addr, wr), wr ? wdata : 8'h00};
        mresp = sresp;
      end
      if (k == 32 * DIV) begin
        exp_st = mresp[15:8];
        exp_rd = mresp[7:0];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      automatic bit act_frame = (k >= 0) && (k < 32 * DIV);
      automatic int h = act_frame ? k / DIV : 0;
      automatic logic e_ss = !act_frame;
      automatic logic e_sclk = act_frame ? logic'(h % 2) : 1'b0;
      automatic logic e_mosi = act_frame ? mframe[15 - h / 2] : 1'b0;
      chk(ss_n === e_ss, "R4 ss_n", ss_n, e_ss);
      chk(sclk === e_sclk, "R4 sclk", sclk, e_sclk);
      chk(mosi === e_mosi, (h / 2 < 8) ? "R2 mosi" : "R3 mosi", mosi, e_mosi);
      chk(busy === (k >= 0), "R9 busy", busy, k >= 0);
      chk(done === (k == 32 * DIV), "R8 done", done, k == 32 * DIV);
      chk(status === exp_st, "R6 status", status, exp_st);
      chk(rdata === exp_rd, "R7 rdata", rdata, exp_rd);
    end
  end

  task automatic run(input logic [4:0] r, input logic w, input logic [7:0] d,
                     input logic [15:0] resp, input bit inject);
    int n;
    logic [15:0] frame;
    frame = {cmd_of(r, w), w ? d : 8'h00};
    sresp = resp; reg_addr = r; wr = w; wdata = d;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    n = 0;
    while (!done) begin
      if (inject && n == 10) begin
        reg_addr = 5'd5; wr = 1'b1; wdata = 8'hFF; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk); n++;
    end
    start = 1'b0;
    chk(n == 32 * DIV, "R8 length", n, 32 * DIV);
    chk(scap[15:8] == frame[15:8], "R2 command", scap[15:8], frame[15:8]);
    chk(scap[7:0] == frame[7:0], "R3 data byte", scap[7:0], frame[7:0]);
    chk(status == resp[15:8], "R6 R5 status", status, resp[15:8]);
    chk(rdata == resp[7:0], "R7 R5 rdata", rdata, resp[7:0]);
    n = 0;
    while (busy) begin @(negedge clk); n++; end
    chk(n == 2 * DIV, "R10 busy tail", n, 2 * DIV);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ss_n === 1'b1 && sclk === 1'b0 && mosi === 1'b0, "R1 reset lines",
        {ss_n, sclk, mosi}, 3'b100);
    chk(busy === 1'b0 && done === 1'b0, "R1 reset flags", {busy, done}, 0);
    chk(rdata === 8'h00 && status === 8'h00, "R1 reset data", {status, rdata}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ss_n === 1'b1 && !busy, "R1 idle", {ss_n, busy}, 2'b10);

    run(5'd18, 1'b0, 8'h77, 16'hA53C, 1'b0);
    run(5'd27, 1'b1, 8'hC1, 16'h5A00, 1'b0);
    run(5'd31, 1'b0, 8'h00, 16'hFF81, 1'b0);
    run(5'd0,  1'b1, 8'h00, 16'h01FE, 1'b0);
    run(5'd13, 1'b0, 8'h00, 16'h1234, 1'b1);
    repeat (3) @(negedge clk);
    chk(!busy && ss_n, "R9 ignored start", {busy, ss_n}, 2'b01);

    begin
      int hi;
      sresp = 16'h8001; reg_addr = 5'd7; wr = 1'b1; wdata = 8'h80;
      @(negedge clk) start = 1'b1;
      while (!done) @(negedge clk);
      chk(status == 8'h80 && rdata == 8'h01, "R6 R7 b2b first", {status, rdata}, 16'h8001);
      hi = 0;
      while (ss_n) begin hi++; @(negedge clk); end
      start = 1'b0;
      chk(hi == 2 * DIV + 1, "R10 gap", hi, 2 * DIV + 1);
      while (!done) @(negedge clk);
      chk(scap == {8'h3A, 8'h80}, "R2 R3 b2b frame", scap, 16'h3A80);
      while (busy) @(negedge clk);
    end

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule